// File: doc/BRIEF.md
# Redundant Bundle Threshold Voter

This block collapses a bundle of N redundant wires, all meant to carry the same logical value, into one three-way verdict. On every cycle where the input strobe is high it counts the stimulated (logic 1) wires and places that count against a lower bound and an upper bound. A count at or above the upper bound reads as a logical true, a count at or below the lower bound reads as a logical false, and anything strictly in between is undecided and raises a malfunction flag. The verdict, the count and the flag are registered and appear one cycle after the strobe, together with their own valid bit.

The two bounds come from a critical fraction Δ, strictly between 0 and 0.5, held as an F-bit fixed-point fraction q/2^F. The lower bound is floor(Δ·N) and the upper bound is ceil((1−Δ)·N), which reduces to N minus the lower bound. The bounds reset to values derived at elaboration from a default Δ, and a configuration port can later replace them either from a new Δ or with two integer bounds given directly. Loads that would break the ordering of the bounds are refused.

Top module: `bundle_vote_unit`

## Requirements
- R1: After reset, out_valid, out_malfunction and out_count are 0, out_verdict is 00, and the bounds are lo = floor(DEF_DELTA_Q·N/2^F) and hi = N − lo (lo 2 and hi 18 for the defaults N = 20, F = 8, DEF_DELTA_Q = 26).
- R2: One cycle after a cycle with in_valid high, out_valid is high and out_count equals the number of 1 bits in the in_bundle sampled with that strobe.
- R3: The verdict is 01 (true) when the sampled count is greater than or equal to hi.
- R4: The verdict is 00 (false) when the sampled count is less than or equal to lo.
- R5: The verdict is 10 (undecided) when lo < count < hi; out_malfunction is high exactly when out_valid is high and the verdict is 10; code 11 never appears.
- R6: A load with cfg_load high and cfg_mode 0 sets lo = floor(cfg_delta·N/2^F) and hi = N − lo.
- R7: A load with cfg_load high and cfg_mode 1 sets lo = cfg_lo and hi = cfg_hi.
- R8: A fraction load whose cfg_delta is 0 or at least 2^(F−1) (Δ outside the open interval 0 to 0.5) is ignored and the bounds keep their values.
- R9: A direct load with cfg_lo ≥ cfg_hi or cfg_hi > N is ignored; at all times lo < hi ≤ N.
- R10: A sample taken in the same cycle as a load is judged against the bounds in force before that load; the new bounds apply from the following cycle.
- R11: In a cycle after in_valid was low, out_valid is 0, out_malfunction is 0, and out_count and out_verdict keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe marking a bundle to judge |
| in_bundle | input | N | The redundant wires, 1 = stimulated |
| cfg_load | input | 1 | Request to replace the bounds |
| cfg_mode | input | 1 | 0 = derive from cfg_delta, 1 = take cfg_lo/cfg_hi |
| cfg_delta | input | F | Critical fraction as cfg_delta/2^F |
| cfg_lo | input | CW | Direct lower bound |
| cfg_hi | input | CW | Direct upper bound |
| out_valid | output | 1 | Verdict and count are fresh this cycle |
| out_verdict | output | 2 | 00 false, 01 true, 10 undecided |
| out_count | output | CW | Stimulated wire count, CW = $clog2(N+1) |
| out_malfunction | output | 1 | High with an undecided verdict |

## Verification
The hardest situation to reach from the ports is the edge of each band: the counts equal to lo and to hi, and the narrowest configurations where the undecided band is empty (hi = lo + 1) or where lo is 0 and hi is N. The bench reaches them by loading fractions and direct bounds chosen to land there and then sweeping every count from 0 to N, each count at two different wire placements. A load issued in the very cycle of a sample is set up deliberately so that the old and new bounds give different verdicts for the same count.

// File: rtl/bdu_pkg.sv
package bdu_pkg;

  typedef enum logic [1:0] {
    VERD_FALSE = 2'b00,
    VERD_TRUE  = 2'b01,
    VERD_UNDEC = 2'b10
  } verdict_e;

  // floor(q * n / 2^frac_w): the lower bound for a fraction q/2^frac_w
  function automatic int unsigned lo_from_delta(input int unsigned q,
                                                input int unsigned n,
                                                input int unsigned frac_w);
    return (q * n) >> frac_w;
  endfunction

  // ceil((1 - q/2^frac_w) * n) equals n minus the floor above
  function automatic int unsigned hi_from_delta(input int unsigned q,
                                                input int unsigned n,
                                                input int unsigned frac_w);
    return n - lo_from_delta(q, n, frac_w);
  endfunction

  // fraction must lie strictly between 0 and one half
  function automatic bit delta_ok(input int unsigned q,
                                  input int unsigned frac_w);
    return (q != 0) && (q < (32'd1 << (frac_w - 1)));
  endfunction

  function automatic bit bounds_ok(input int unsigned lo,
                                   input int unsigned hi,
                                   input int unsigned n);
    return (lo < hi) && (hi <= n);
  endfunction

endpackage

// File: rtl/bdu_popcount.sv
module bdu_popcount #(
  parameter int N   = 20,
  parameter int GRP = 4,
  parameter int CW  = $clog2(N + 1)
) (
  input  logic [N-1:0]  bits,
  output logic [CW-1:0] count
);

  localparam int NGRP = (N + GRP - 1) / GRP;
  localparam int PAD  = NGRP * GRP;
  localparam int GCW  = $clog2(GRP + 1);

  logic [PAD-1:0]      padded;
  logic [NGRP*GCW-1:0] parts;

  assign padded = PAD'(bits);

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic [GCW-1:0] part;
    always_comb begin
      part = '0;
      for (int i = 0; i < GRP; i++) begin
        part = part + GCW'(padded[g*GRP + i]);
      end
    end
    assign parts[g*GCW +: GCW] = part;
  end

  always_comb begin
    count = '0;
    for (int g = 0; g < NGRP; g++) begin
      count = count + CW'(parts[g*GCW +: GCW]);
    end
  end

endmodule

// File: rtl/bdu_bounds.sv
module bdu_bounds
  import bdu_pkg::*;
#(
  parameter int N           = 20,
  parameter int F           = 8,
  parameter int CW          = $clog2(N + 1),
  parameter int DEF_DELTA_Q = 26
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic          cfg_mode,
  input  logic [F-1:0]  cfg_delta,
  input  logic [CW-1:0] cfg_lo,
  input  logic [CW-1:0] cfg_hi,
  output logic [CW-1:0] lo,
  output logic [CW-1:0] hi,
  output logic          load_accept
);

  localparam int unsigned DEF_LO = lo_from_delta(DEF_DELTA_Q, N, F);
  localparam int unsigned DEF_HI = hi_from_delta(DEF_DELTA_Q, N, F);

  logic [CW-1:0] cand_lo;
  logic [CW-1:0] cand_hi;
  logic          cand_ok;

  always_comb begin
    if (cfg_mode) begin
      cand_lo = cfg_lo;
      cand_hi = cfg_hi;
      cand_ok = bounds_ok(32'(cfg_lo), 32'(cfg_hi), N);
    end else begin
      cand_lo = CW'(lo_from_delta(32'(cfg_delta), N, F));
      cand_hi = CW'(hi_from_delta(32'(cfg_delta), N, F));
      cand_ok = delta_ok(32'(cfg_delta), F);
    end
  end

  assign load_accept = cfg_load && cand_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo <= CW'(DEF_LO);
      hi <= CW'(DEF_HI);
    end else if (load_accept) begin
      lo <= cand_lo;
      hi <= cand_hi;
    end
  end

endmodule

// File: rtl/bdu_classify.sv
module bdu_classify
  import bdu_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] lo,
  input  logic [CW-1:0] hi,
  output verdict_e      verdict
);

  logic at_or_above_hi;
  logic at_or_below_lo;

  assign at_or_above_hi = (count >= hi);
  assign at_or_below_lo = (count <= lo);

  always_comb begin
    if (at_or_above_hi)      verdict = VERD_TRUE;
    else if (at_or_below_lo) verdict = VERD_FALSE;
    else                     verdict = VERD_UNDEC;
  end

endmodule

// File: rtl/bundle_vote_unit.sv
module bundle_vote_unit
  import bdu_pkg::*;
#(
  parameter int N           = 20,
  parameter int F           = 8,
  parameter int DEF_DELTA_Q = 26,
  parameter int GRP         = 4,
  parameter int CW          = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [N-1:0]  in_bundle,
  input  logic          cfg_load,
  input  logic          cfg_mode,
  input  logic [F-1:0]  cfg_delta,
  input  logic [CW-1:0] cfg_lo,
  input  logic [CW-1:0] cfg_hi,
  output logic          out_valid,
  output logic [1:0]    out_verdict,
  output logic [CW-1:0] out_count,
  output logic          out_malfunction
);

  // named internal events, visible to the bound checker
  logic [CW-1:0] live_count;
  logic [CW-1:0] cur_lo;
  logic [CW-1:0] cur_hi;
  logic          cfg_accept;
  verdict_e      raw_verdict;

  bdu_popcount #(.N(N), .GRP(GRP), .CW(CW)) u_pop (
    .bits  (in_bundle),
    .count (live_count)
  );

  bdu_bounds #(.N(N), .F(F), .CW(CW), .DEF_DELTA_Q(DEF_DELTA_Q)) u_bnd (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_load    (cfg_load),
    .cfg_mode    (cfg_mode),
    .cfg_delta   (cfg_delta),
    .cfg_lo      (cfg_lo),
    .cfg_hi      (cfg_hi),
    .lo          (cur_lo),
    .hi          (cur_hi),
    .load_accept (cfg_accept)
  );

  bdu_classify #(.CW(CW)) u_cls (
    .count   (live_count),
    .lo      (cur_lo),
    .hi      (cur_hi),
    .verdict (raw_verdict)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid       <= 1'b0;
      out_verdict     <= VERD_FALSE;
      out_count       <= '0;
      out_malfunction <= 1'b0;
    end else begin
      out_valid       <= in_valid;
      out_malfunction <= in_valid && (raw_verdict == VERD_UNDEC);
      if (in_valid) begin
        out_verdict <= raw_verdict;
        out_count   <= live_count;
      end
    end
  end

endmodule

// File: rtl/bdu_checker.sv
module bdu_checker #(
  parameter int N  = 20,
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [N-1:0]  in_bundle,
  input logic          out_valid,
  input logic [1:0]    out_verdict,
  input logic [CW-1:0] out_count,
  input logic          out_malfunction,
  input logic [CW-1:0] cur_lo,
  input logic [CW-1:0] cur_hi
);

  localparam logic [CW-1:0] N_C = CW'(N);

  p_valid_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_count == CW'($countones($past(in_bundle)))));

  p_true_band_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (CW'($countones(in_bundle)) >= cur_hi)) |=> (out_verdict == 2'b01));

  p_false_band_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (CW'($countones(in_bundle)) <= cur_lo)) |=> (out_verdict == 2'b00));

  p_legal_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_verdict != 2'b11);

  p_malf_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_malfunction == (out_valid && (out_verdict == 2'b10)));

  p_bounds_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_lo < cur_hi) && (cur_hi <= N_C));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_count) && $stable(out_verdict)));

endmodule

bind bundle_vote_unit bdu_checker #(.N(N), .CW(CW)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .in_valid        (in_valid),
  .in_bundle       (in_bundle),
  .out_valid       (out_valid),
  .out_verdict     (out_verdict),
  .out_count       (out_count),
  .out_malfunction (out_malfunction),
  .cur_lo          (cur_lo),
  .cur_hi          (cur_hi)
);

// File: tb/bundle_vote_unit_tb.sv
`timescale 1ns/1ps
module bundle_vote_unit_tb;

  localparam int N  = 20;
  localparam int F  = 8;
  localparam int DQ = 26;
  localparam int CW = $clog2(N + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [N-1:0]  in_bundle = '0;
  logic          cfg_load = 1'b0;
  logic          cfg_mode = 1'b0;
  logic [F-1:0]  cfg_delta = '0;
  logic [CW-1:0] cfg_lo = '0;
  logic [CW-1:0] cfg_hi = '0;
  logic          out_valid;
  logic [1:0]    out_verdict;
  logic [CW-1:0] out_count;
  logic          out_malfunction;

  int n_tests = 0;
  int n_fail  = 0;
  int m_lo, m_hi;

  always #10 clk = ~clk;

  bundle_vote_unit #(.N(N), .F(F), .DEF_DELTA_Q(DQ)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bundle(in_bundle),
    .cfg_load(cfg_load), .cfg_mode(cfg_mode), .cfg_delta(cfg_delta),
    .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .out_valid(out_valid),
    .out_verdict(out_verdict), .out_count(out_count),
    .out_malfunction(out_malfunction)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] make_bundle(input int k, input int rot);
    logic [N-1:0] b = '0;
    for (int i = 0; i < N; i++) b[(i * 7 + rot) % N] = (i < k);
    return b;
  endfunction

  function automatic int expect_code(input int k, input int lo, input int hi);
    if (k >= hi) return 1;
    if (k <= lo) return 0;
    return 2;
  endfunction

  // drive one strobed sample, check after the capturing edge
  task automatic sample(input int k, input int rot, input int lo, input int hi,
                        input string req);
    int ev;
    @(negedge clk);
    in_valid  = 1'b1;
    in_bundle = make_bundle(k, rot);
    @(posedge clk);
    #1;
    ev = expect_code(k, lo, hi);
    check(out_valid == 1'b1, {req, "/R2 valid"}, int'(out_valid), 1);
    check(int'(out_count) == k, {req, "/R2 count"}, int'(out_count), k);
    check(int'(out_verdict) == ev, {req, " verdict"}, int'(out_verdict), ev);
    check(out_malfunction == (ev == 2), {req, "/R5 malfunction"},
          int'(out_malfunction), int'(ev == 2));
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic sweep(input string req);
    for (int k = 0; k <= N; k++) begin
      sample(k, 0, m_lo, m_hi, req);
      sample(k, k * 3 + 1, m_lo, m_hi, req);
    end
  endtask

  task automatic load_delta(input int q);
    @(negedge clk);
    cfg_load = 1'b1; cfg_mode = 1'b0; cfg_delta = F'(q);
    @(negedge clk);
    cfg_load = 1'b0;
    if (q > 0 && q < (1 << (F - 1))) begin
      m_lo = (q * N) / (1 << F);
      m_hi = N - m_lo;
    end
  endtask

  task automatic load_direct(input int lo, input int hi);
    @(negedge clk);
    cfg_load = 1'b1; cfg_mode = 1'b1; cfg_lo = CW'(lo); cfg_hi = CW'(hi);
    @(negedge clk);
    cfg_load = 1'b0;
    if (lo < hi && hi <= N) begin
      m_lo = lo;
      m_hi = hi;
    end
  endtask

  initial begin
    #(20ns * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    check(out_valid == 1'b0, "R1 valid", int'(out_valid), 0);
    check(out_verdict == 2'b00, "R1 verdict", int'(out_verdict), 0);
    check(out_count == '0, "R1 count", int'(out_count), 0);
    check(out_malfunction == 1'b0, "R1 malfunction", int'(out_malfunction), 0);

    // R1: default bounds 2 / 18; R3 R4 R5 across all counts
    m_lo = (DQ * N) / 256;
    m_hi = N - m_lo;
    sweep("R1/R3/R4");

    // R11: idle cycle holds count and verdict
    sample(19, 5, m_lo, m_hi, "R3");
    @(posedge clk);
    #1;
    check(out_valid == 1'b0, "R11 valid", int'(out_valid), 0);
    check(out_count == CW'(19), "R11 count", int'(out_count), 19);
    check(out_verdict == 2'b01, "R11 verdict", int'(out_verdict), 1);
    check(out_malfunction == 1'b0, "R11 malfunction", int'(out_malfunction), 0);
    sample(10, 2, m_lo, m_hi, "R5");
    @(posedge clk);
    #1;
    check(out_malfunction == 1'b0, "R11 malf idle", int'(out_malfunction), 0);
    check(out_verdict == 2'b10, "R11 verdict undec", int'(out_verdict), 2);

    // R6: fraction loads (0.25 -> 5/15, 127/256 -> 9/11, 1/256 -> 0/20)
    load_delta(64);  sweep("R6 q64");
    load_delta(127); sweep("R6 q127");
    load_delta(1);   sweep("R6 q1");

    // R8: out-of-range fractions leave 0/20
    load_delta(0);
    load_delta(128);
    load_delta(255);
    sweep("R8");

    // R7: direct bounds, including an empty undecided band
    load_direct(7, 8);  sweep("R7 7/8");
    load_direct(3, 17); sweep("R7 3/17");

    // R9: bad direct loads leave 3/17
    load_direct(8, 8);
    load_direct(9, 4);
    load_direct(2, 21);
    sweep("R9");

    // R10: load and sample in one cycle; count 5 undecided under 3/17
    @(negedge clk);
    cfg_load = 1'b1; cfg_mode = 1'b1; cfg_lo = CW'(10); cfg_hi = CW'(11);
    in_valid = 1'b1; in_bundle = make_bundle(5, 4);
    @(posedge clk);
    #1;
    check(out_verdict == 2'b10, "R10 old bounds", int'(out_verdict), 2);
    @(negedge clk);
    cfg_load = 1'b0; in_valid = 1'b0;
    m_lo = 10; m_hi = 11;
    sample(5, 4, m_lo, m_hi, "R10 new bounds");
    sample(11, 1, m_lo, m_hi, "R10 new hi");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule